// File: doc/BRIEF.md
# I2C Stream Command Sequencer

This block sits between a software-facing command queue and a byte-level I2C engine. Software writes 10-bit entries into a 16-entry transmit queue. Each entry holds a byte and two framing flags. Bit 8 asks for a START, or a repeated START when the bus is already owned, with the byte sent as an address. Bit 9 asks for a STOP once that byte is done. The sequencer reads the entries in order and issues one byte operation at a time over a valid/ready command channel. It then waits for the engine's response before it issues the next one.

A read is written as two entries. The first is an address with its direction bit (bit 0) set. The second gives the number of bytes to fetch, 0 to 255. The sequencer issues that many single-byte reads, asking the engine to ACK every byte except the last, and stores the returned bytes in a 16-entry receive queue. Framing errors are handled here too. A NACK on an address or on a written byte discards the rest of that message and closes the bus. When the queue runs dry in the middle of a message, the sequencer holds the clock low. Zero-based occupancy figures and a receive-level flag are provided for the host.

Top module: `i2c_dyn_seq`

## Requirements
- R1: After reset both queues are empty, `tx_occ` and `rx_occ` read 0, `tx_free` reads DEPTH-1, and `cmd_valid`, `hold_scl`, `tx_error` and `bus_free` are low.
- R2: Operation codes on `cmd_op` are 1 = START+address, 2 = repeated START+address, 3 = write byte, 4 = read byte, 5 = STOP. An entry with bit 8 set issues code 1 when the bus is not owned and code 2 when it is owned. In both cases `cmd_byte` carries bits 7:0 of the entry.
- R3: While the bus is owned, an entry with bit 8 clear issues a write-byte operation carrying its low byte. If the entry has bit 9 set, a STOP is issued after that byte's response.
- R4: An entry with bits 8 and 9 both set and bit 0 clear produces a START+address followed directly by a STOP, with no data operation in between.
- R5: After an address with bit 0 set is acknowledged, the next entry gives the byte count N in bits 7:0. N read operations follow. `cmd_ack` is 1 for each of them except the last, where it is 0. The returned bytes enter the receive queue in order. Bit 9 of the count entry selects whether a STOP follows the last byte.
- R6: A read count of 0 issues no read operations.
- R7: A NACK response to a START, repeated START or write pulses `tx_error` for one cycle. The sequencer then discards the queued entries of that message, up to and including the first one with bit 9 set, but never an entry with bit 8 set. It then issues a STOP.
- R8: While the bus is owned, the message has no STOP pending and the transmit queue is empty, `hold_scl` is high and no operation is issued. Processing resumes when an entry arrives.
- R9: `bus_free` pulses for one cycle when a STOP response arrives while the transmit queue is empty.
- R10: Occupancy outputs are zero-based: entries minus one when non-empty, 0 when empty. `tx_free` equals DEPTH-1 minus `tx_occ`. A write to a full transmit queue is ignored.
- R11: `rx_level` is high exactly when the receive queue holds at least `rx_thresh`+1 entries.
- R12: A read operation is not offered while the receive queue is full. It is offered once the queue has space again.
- R13: An entry with bit 8 clear that arrives while the bus is not owned is dropped without issuing any operation.
- R14: Once offered, an operation keeps `cmd_valid`, `cmd_op` and `cmd_byte` steady until `cmd_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wr_en | input | 1 | Write one entry to the transmit queue |
| tx_wr_data | input | 10 | Entry: bits 7:0 byte, bit 8 START, bit 9 STOP |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_occ | output | $clog2(DEPTH) | Transmit occupancy, zero-based |
| tx_free | output | $clog2(DEPTH) | DEPTH-1 minus `tx_occ` |
| rx_rd_en | input | 1 | Remove the head byte of the receive queue |
| rx_rd_data | output | 8 | Head byte of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_occ | output | $clog2(DEPTH) | Receive occupancy, zero-based |
| rx_thresh | input | $clog2(DEPTH) | Receive level setting, zero-based |
| rx_level | output | 1 | Receive entries at least `rx_thresh`+1 |
| cmd_valid | output | 1 | Operation offered to the byte engine |
| cmd_ready | input | 1 | Byte engine accepts the operation |
| cmd_op | output | 3 | Operation code |
| cmd_byte | output | 8 | Address or data byte |
| cmd_ack | output | 1 | For reads: 1 = ACK the byte, 0 = NACK it |
| rsp_valid | input | 1 | Byte engine finished the accepted operation |
| rsp_nack | input | 1 | The address or written byte was not acknowledged |
| rsp_data | input | 8 | Byte returned by a read |
| hold_scl | output | 1 | Clock held low while waiting for entries |
| tx_error | output | 1 | One-cycle pulse on a NACK to address or data |
| bus_free | output | 1 | One-cycle pulse when the bus is released with nothing queued |

## Verification
The bench builds the block with its default depth of 16. This depth is small enough to sweep every read count from 0 up to a full receive queue, plus counts that overflow it, so the ACK/NACK pattern, the zero-based occupancy, the level flag and the full-queue stall are all checked at every fill level. Filling the transmit queue one entry at a time while the engine refuses commands covers every transmit occupancy up to full. Write lengths from zero to several bytes, NACKs on both the address and a data byte, and a stalling engine complete the framing cases.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  localparam int ENTRY_W   = 10;
  localparam int START_POS = 8;
  localparam int STOP_POS  = 9;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_START  = 3'd1,
    OP_RSTART = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4,
    OP_STOP   = 3'd5
  } seq_op_e;

  // Zero-based occupancy: empty and single entry both read 0.
  function automatic int zero_based(input int cnt);
    return (cnt == 0) ? 0 : cnt - 1;
  endfunction

  // Free slots as seen from the zero-based occupancy.
  function automatic int free_space(input int depth, input int zb);
    return depth - 1 - zb;
  endfunction

  // Level reached when the count reaches the setting plus one.
  function automatic logic level_hit(input int cnt, input int thr);
    return cnt >= thr + 1;
  endfunction

endpackage

// File: rtl/seq_fifo.sv
module seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import i2cseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRY_W-1:0] head,
  input  logic               head_vld,
  output logic               pop,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [2:0]         cmd_op,
  output logic [7:0]         cmd_byte,
  output logic               cmd_ack,
  input  logic               rsp_valid,
  input  logic               rsp_nack,
  input  logic [7:0]         rsp_data,
  output logic               rx_push,
  output logic [7:0]         rx_data,
  input  logic               rx_full,
  output logic               hold_scl,
  output logic               tx_error,
  output logic               bus_free
);
  typedef enum logic [2:0] {
    ST_DISPATCH, ST_ISSUE, ST_WAIT, ST_LEN, ST_FLUSH
  } seq_state_e;

  seq_state_e state;
  seq_op_e    op_q;
  logic [7:0] byte_q;
  logic [7:0] rd_left;
  logic       master_q, read_q, stop_q, rd_stop_q;
  logic       h_start, h_stop, addr_op, rsp_here;

  assign h_start  = head[START_POS];
  assign h_stop   = head[STOP_POS];
  assign addr_op  = (op_q == OP_START) || (op_q == OP_RSTART) || (op_q == OP_WRITE);
  assign rsp_here = (state == ST_WAIT) && rsp_valid;

  assign cmd_op   = op_q;
  assign cmd_byte = byte_q;
  assign cmd_ack  = (rd_left > 8'd1);
  assign rx_data  = rsp_data;

  always_comb begin
    cmd_valid = (state == ST_ISSUE) && !((op_q == OP_READ) && rx_full);
    rx_push   = rsp_here && (op_q == OP_READ);
    tx_error  = rsp_here && rsp_nack && addr_op;
    bus_free  = rsp_here && (op_q == OP_STOP) && !head_vld;
    hold_scl  = master_q && !head_vld && ((state == ST_DISPATCH) || (state == ST_LEN));
    case (state)
      ST_DISPATCH, ST_LEN: pop = head_vld;
      ST_FLUSH:            pop = head_vld && !h_start && !stop_q;
      default:             pop = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_DISPATCH;
      op_q      <= OP_NONE;
      byte_q    <= '0;
      rd_left   <= '0;
      master_q  <= 1'b0;
      read_q    <= 1'b0;
      stop_q    <= 1'b0;
      rd_stop_q <= 1'b0;
    end else begin
      case (state)
        ST_DISPATCH: begin
          if (head_vld) begin
            if (h_start) begin
              op_q   <= master_q ? OP_RSTART : OP_START;
              byte_q <= head[7:0];
              stop_q <= h_stop;
              read_q <= head[0];
              state  <= ST_ISSUE;
            end else if (master_q) begin
              op_q   <= OP_WRITE;
              byte_q <= head[7:0];
              stop_q <= h_stop;
              read_q <= 1'b0;
              state  <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (cmd_valid && cmd_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            case (op_q)
              OP_START, OP_RSTART, OP_WRITE: begin
                master_q <= 1'b1;
                if (rsp_nack)     state <= ST_FLUSH;
                else if (read_q)  state <= ST_LEN;
                else if (stop_q) begin
                  op_q  <= OP_STOP;
                  state <= ST_ISSUE;
                end else          state <= ST_DISPATCH;
              end
              OP_READ: begin
                rd_left <= rd_left - 1'b1;
                if (rd_left == 8'd1) begin
                  if (rd_stop_q) begin
                    op_q  <= OP_STOP;
                    state <= ST_ISSUE;
                  end else state <= ST_DISPATCH;
                end else state <= ST_ISSUE;
              end
              default: begin
                master_q <= 1'b0;
                state    <= ST_DISPATCH;
              end
            endcase
          end
        end
        ST_LEN: begin
          if (head_vld) begin
            rd_left   <= head[7:0];
            rd_stop_q <= h_stop;
            if (head[7:0] == 8'd0) begin
              if (h_stop) begin
                op_q  <= OP_STOP;
                state <= ST_ISSUE;
              end else state <= ST_DISPATCH;
            end else begin
              op_q  <= OP_READ;
              state <= ST_ISSUE;
            end
          end
        end
        default: begin
          if (stop_q || !head_vld || h_start) begin
            op_q  <= OP_STOP;
            state <= ST_ISSUE;
          end else if (h_stop) begin
            stop_q <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_dyn_seq.sv
module i2c_dyn_seq
  import i2cseq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tx_wr_en,
  input  logic [9:0]                 tx_wr_data,
  output logic                       tx_full,
  output logic                       tx_empty,
  output logic [$clog2(DEPTH)-1:0]   tx_occ,
  output logic [$clog2(DEPTH)-1:0]   tx_free,
  input  logic                       rx_rd_en,
  output logic [7:0]                 rx_rd_data,
  output logic                       rx_empty,
  output logic                       rx_full,
  output logic [$clog2(DEPTH)-1:0]   rx_occ,
  input  logic [$clog2(DEPTH)-1:0]   rx_thresh,
  output logic                       rx_level,
  output logic                       cmd_valid,
  input  logic                       cmd_ready,
  output logic [2:0]                 cmd_op,
  output logic [7:0]                 cmd_byte,
  output logic                       cmd_ack,
  input  logic                       rsp_valid,
  input  logic                       rsp_nack,
  input  logic [7:0]                 rsp_data,
  output logic                       hold_scl,
  output logic                       tx_error,
  output logic                       bus_free
);
  localparam int OW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [ENTRY_W-1:0] tx_head;
  logic [CW-1:0]      tx_cnt, rx_cnt;
  logic               tx_pop_w, rx_push_w;
  logic [7:0]         rx_push_data;

  seq_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_wr_en), .wdata(tx_wr_data),
    .pop(tx_pop_w), .rdata(tx_head), .full(tx_full), .empty(tx_empty),
    .count(tx_cnt)
  );

  seq_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push_w), .wdata(rx_push_data),
    .pop(rx_rd_en), .rdata(rx_rd_data), .full(rx_full), .empty(rx_empty),
    .count(rx_cnt)
  );

  seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .head(tx_head), .head_vld(!tx_empty),
    .pop(tx_pop_w), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_ack(cmd_ack),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_data(rsp_data),
    .rx_push(rx_push_w), .rx_data(rx_push_data), .rx_full(rx_full),
    .hold_scl(hold_scl), .tx_error(tx_error), .bus_free(bus_free)
  );

  assign tx_occ   = OW'(zero_based(int'(tx_cnt)));
  assign tx_free  = OW'(free_space(DEPTH, zero_based(int'(tx_cnt))));
  assign rx_occ   = OW'(zero_based(int'(rx_cnt)));
  assign rx_level = level_hit(int'(rx_cnt), int'(rx_thresh));
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic [7:0] cmd_byte,
  input logic       rx_push,
  input logic       rx_full,
  input logic       tx_pop,
  input logic       tx_empty,
  input logic       tx_error,
  input logic       rsp_valid,
  input logic       rsp_nack,
  input logic       bus_free,
  input logic       hold_scl
);
  p_cmd_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));

  p_read_space_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 3'd4) |-> !rx_full);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_scl |-> tx_empty && !cmd_valid);

  p_err_on_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_error |-> rsp_valid && rsp_nack);

  p_free_on_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free |-> rsp_valid && tx_empty && !hold_scl);
endmodule

bind i2c_dyn_seq seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_byte(cmd_byte), .rx_push(rx_push_w), .rx_full(rx_full),
  .tx_pop(tx_pop_w), .tx_empty(tx_empty), .tx_error(tx_error),
  .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .bus_free(bus_free),
  .hold_scl(hold_scl)
);

// File: tb/sim_i2c_dyn_seq.sv
`timescale 1ns/1ps
module sim_i2c_dyn_seq;
  localparam int DEPTH = 16;
  localparam int OW = $clog2(DEPTH);
  localparam int C_START = 1, C_RSTART = 2, C_WRITE = 3, C_READ = 4, C_STOP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_wr_en = 1'b0;
  logic [9:0] tx_wr_data = '0;
  logic tx_full, tx_empty, rx_empty, rx_full, rx_level;
  logic [OW-1:0] tx_occ, tx_free, rx_occ;
  logic rx_rd_en = 1'b0;
  logic [7:0] rx_rd_data;
  logic [OW-1:0] rx_thresh = OW'(3);
  logic cmd_valid, cmd_ack;
  logic cmd_ready = 1'b0;
  logic [2:0] cmd_op;
  logic [7:0] cmd_byte;
  logic rsp_valid = 1'b0, rsp_nack = 1'b0;
  logic [7:0] rsp_data = '0;
  logic hold_scl, tx_error, bus_free;

  always #4 clk = ~clk;

  i2c_dyn_seq #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_occ(tx_occ), .tx_free(tx_free),
    .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty),
    .rx_full(rx_full), .rx_occ(rx_occ), .rx_thresh(rx_thresh), .rx_level(rx_level),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_ack(cmd_ack), .rsp_valid(rsp_valid),
    .rsp_nack(rsp_nack), .rsp_data(rsp_data), .hold_scl(hold_scl),
    .tx_error(tx_error), .bus_free(bus_free)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int log_op [256];
  int log_byte [256];
  int log_ack [256];
  int log_data [256];
  int log_n = 0;
  int nack_idx = -1;
  bit eng_block = 0, stall_mode = 0, tick = 0;
  int busy = 0;
  bit pend_nack = 0;
  logic [7:0] pend_data = '0;
  int err_cnt = 0, free_cnt = 0;

  // Byte engine model
  always @(negedge clk) begin
    cmd_ready = 1'b0;
    rsp_valid = 1'b0;
    rsp_nack  = 1'b0;
    tick = ~tick;
    if (rst_n) begin
      if (busy > 0) begin
        busy--;
        if (busy == 0) begin
          rsp_valid = 1'b1;
          rsp_nack  = pend_nack;
          rsp_data  = pend_data;
        end
      end else if (cmd_valid && !eng_block && !(stall_mode && tick)) begin
        cmd_ready = 1'b1;
        log_op[log_n]   = int'(cmd_op);
        log_byte[log_n] = int'(cmd_byte);
        log_ack[log_n]  = int'(cmd_ack);
        pend_nack = (log_n == nack_idx);
        pend_data = 8'h40 + 8'(log_n);
        log_data[log_n] = int'(pend_data);
        log_n++;
        busy = 2;
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (tx_error) err_cnt++;
    if (bus_free) free_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] e);
    @(negedge clk); #1;
    tx_wr_en = 1'b1; tx_wr_data = e;
    @(negedge clk); #1;
    tx_wr_en = 1'b0;
  endtask

  task automatic pop_rx(output int v);
    @(negedge clk); #1;
    v = int'(rx_rd_data);
    rx_rd_en = 1'b1;
    @(negedge clk); #1;
    rx_rd_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clear_log();
    @(negedge clk); #1;
    log_n = 0;
  endtask

  task automatic chk_op(input int i, input int op, input int b, input string req);
    chk(log_op[i] == op, req, $sformatf("op[%0d]", i), log_op[i], op);
    if (b >= 0) chk(log_byte[i] == b, req, $sformatf("byte[%0d]", i), log_byte[i], b);
  endtask

  task automatic run_read(input int len);
    int fc, v;
    clear_log();
    fc = free_cnt;
    push(10'h1A1);
    push(10'h200 | 10'(len));
    settle(40 + 6 * len);
    chk(log_n == len + 2, (len == 0) ? "R6" : "R5", $sformatf("read len %0d op count", len), log_n, len + 2);
    chk_op(0, C_START, 8'hA1, "R2");
    for (int i = 1; i <= len; i++) begin
      chk(log_op[i] == C_READ, "R5", "read op", log_op[i], C_READ);
      chk(log_ack[i] == ((i < len) ? 1 : 0), "R5", $sformatf("ack of byte %0d/%0d", i, len), log_ack[i], (i < len) ? 1 : 0);
    end
    chk_op(len + 1, C_STOP, -1, "R5");
    chk(int'(rx_occ) == ((len == 0) ? 0 : len - 1), "R10", $sformatf("rx_occ len %0d", len), int'(rx_occ), (len == 0) ? 0 : len - 1);
    chk(rx_level == (len >= 4), "R11", $sformatf("rx_level len %0d", len), int'(rx_level), int'(len >= 4));
    chk(free_cnt == fc + 1, "R9", "bus_free after read", free_cnt, fc + 1);
    for (int i = 1; i <= len; i++) begin
      pop_rx(v);
      chk(v == log_data[i], "R5", $sformatf("rx byte %0d", i), v, log_data[i]);
    end
    chk(rx_empty == 1'b1, "R5", "rx drained", int'(rx_empty), 1);
  endtask

  task automatic run_write(input int n);
    clear_log();
    push((n == 0) ? 10'h3A0 : 10'h1A0);
    for (int i = 1; i <= n; i++) push(((i == n) ? 10'h200 : 10'h000) | 10'(8'h10 + i));
    settle(30 + 8 * n);
    chk(log_n == n + 2, (n == 0) ? "R4" : "R3", $sformatf("write n=%0d op count", n), log_n, n + 2);
    chk_op(0, C_START, 8'hA0, "R2");
    for (int i = 1; i <= n; i++) chk_op(i, C_WRITE, 8'h10 + i, "R3");
    chk_op(n + 1, C_STOP, -1, (n == 0) ? "R4" : "R3");
  endtask

  initial begin
    int v, fc, got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(2);
    // R1 reset state
    chk(tx_empty && rx_empty, "R1", "queues empty", int'({tx_empty, rx_empty}), 3);
    chk(tx_occ == 0 && rx_occ == 0, "R1", "occupancy zero", int'(tx_occ), 0);
    chk(int'(tx_free) == DEPTH - 1, "R1", "tx_free", int'(tx_free), DEPTH - 1);
    chk(!cmd_valid && !hold_scl && !tx_error && !bus_free, "R1", "idle outputs", int'({cmd_valid, hold_scl, tx_error, bus_free}), 0);

    // R13 dropped entry while idle
    clear_log();
    push(10'h033);
    settle(20);
    chk(log_n == 0, "R13", "no op for stray entry", log_n, 0);
    chk(tx_empty == 1'b1, "R13", "stray entry removed", int'(tx_empty), 1);

    // R5/R6/R10/R11 read sweep
    for (int len = 0; len <= DEPTH; len++) run_read(len);

    // R3/R4 write sweep
    for (int n = 0; n <= 5; n++) run_write(n);

    // R14 engine stalls
    stall_mode = 1;
    run_write(4);
    chk(log_n == 6, "R14", "stalled handshake sequence", log_n, 6);
    stall_mode = 0;

    // R8 hold on empty queue
    clear_log();
    push(10'h1A0);
    settle(30);
    chk(log_n == 1, "R8", "waits after address", log_n, 1);
    chk(hold_scl == 1'b1, "R8", "hold_scl high", int'(hold_scl), 1);
    push(10'h255);
    settle(30);
    chk(hold_scl == 1'b0, "R8", "hold released", int'(hold_scl), 0);
    chk(log_n == 3, "R8", "resumed op count", log_n, 3);
    chk_op(1, C_WRITE, 8'h55, "R8");
    chk_op(2, C_STOP, -1, "R3");

    // R2 repeated start
    clear_log();
    eng_block = 1;
    push(10'h1A0); push(10'h011); push(10'h1A1); push(10'h202);
    eng_block = 0;
    settle(80);
    chk(log_n == 6, "R2", "rstart op count", log_n, 6);
    chk_op(0, C_START, 8'hA0, "R2");
    chk_op(1, C_WRITE, 8'h11, "R3");
    chk_op(2, C_RSTART, 8'hA1, "R2");
    chk(log_op[3] == C_READ && log_ack[3] == 1, "R5", "first read ack", log_ack[3], 1);
    chk(log_op[4] == C_READ && log_ack[4] == 0, "R5", "last read nack", log_ack[4], 0);
    chk_op(5, C_STOP, -1, "R5");
    pop_rx(v); pop_rx(v);

    // R7 nack on data byte
    clear_log();
    fc = err_cnt;
    nack_idx = 1;
    eng_block = 1;
    push(10'h1A0); push(10'h001); push(10'h202); push(10'h1A0); push(10'h203);
    eng_block = 0;
    settle(80);
    nack_idx = -1;
    chk(err_cnt == fc + 1, "R7", "tx_error pulse", err_cnt, fc + 1);
    chk(log_n == 6, "R7", "data nack op count", log_n, 6);
    chk_op(1, C_WRITE, 8'h01, "R7");
    chk_op(2, C_STOP, -1, "R7");
    chk_op(3, C_START, 8'hA0, "R7");
    chk_op(4, C_WRITE, 8'h03, "R7");
    chk_op(5, C_STOP, -1, "R7");

    // R7 nack on read address, count entry discarded
    clear_log();
    fc = err_cnt;
    nack_idx = 0;
    eng_block = 1;
    push(10'h1A1); push(10'h205); push(10'h1A0); push(10'h209);
    eng_block = 0;
    settle(60);
    nack_idx = -1;
    chk(err_cnt == fc + 1, "R7", "addr nack tx_error", err_cnt, fc + 1);
    chk(log_n == 5, "R7", "addr nack op count", log_n, 5);
    chk_op(1, C_STOP, -1, "R7");
    chk_op(2, C_START, 8'hA0, "R7");
    chk_op(3, C_WRITE, 8'h09, "R7");
    chk(rx_empty == 1'b1, "R7", "no read after addr nack", int'(rx_empty), 1);

    // R10 transmit occupancy sweep
    clear_log();
    eng_block = 1;
    push(10'h1A0);
    settle(3);
    for (int k = 1; k <= DEPTH; k++) begin
      push(((k == DEPTH) ? 10'h200 : 10'h000) | 10'(k));
      chk(int'(tx_occ) == k - 1, "R10", $sformatf("tx_occ k=%0d", k), int'(tx_occ), k - 1);
      chk(int'(tx_free) == DEPTH - k, "R10", $sformatf("tx_free k=%0d", k), int'(tx_free), DEPTH - k);
    end
    chk(tx_full == 1'b1, "R10", "tx_full", int'(tx_full), 1);
    push(10'h0EE);
    chk(int'(tx_occ) == DEPTH - 1, "R10", "write to full ignored", int'(tx_occ), DEPTH - 1);
    eng_block = 0;
    settle(200);
    chk(log_n == DEPTH + 2, "R10", "full queue drained", log_n, DEPTH + 2);
    chk_op(DEPTH, C_WRITE, DEPTH, "R3");
    chk_op(DEPTH + 1, C_STOP, -1, "R3");

    // R12 read beyond receive capacity
    clear_log();
    push(10'h1A1);
    push(10'h200 | 10'(DEPTH + 2));
    settle(200);
    chk(log_n == DEPTH + 1, "R12", "reads stall at full", log_n, DEPTH + 1);
    chk(rx_full == 1'b1, "R12", "rx_full", int'(rx_full), 1);
    got = 0;
    for (int t = 0; t < 400 && got < DEPTH + 2; t++) begin
      if (!rx_empty) begin
        pop_rx(v);
        got++;
        chk(v == log_data[got], "R12", $sformatf("rx byte %0d", got), v, log_data[got]);
      end else settle(1);
    end
    settle(20);
    chk(got == DEPTH + 2, "R12", "all bytes received", got, DEPTH + 2);
    chk(log_n == DEPTH + 4, "R12", "ops after drain", log_n, DEPTH + 4);
    chk(log_ack[DEPTH + 2] == 0, "R5", "last of long read nacked", log_ack[DEPTH + 2], 0);
    chk(log_ack[DEPTH + 1] == 1, "R5", "second last acked", log_ack[DEPTH + 1], 1);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule